// File: doc/BRIEF.md
# DDR3 Burst-Chop Command Scheduler

This block sits on the controller side of a DDR3-style memory interface, between a request queue and the command/address pins. It takes one READ or WRITE request at a time. Each request carries a bank, a column and a per-request choice between a full 8-beat burst and a 4-beat chopped burst. The block places the command on the bus only once the column spacing rules allow it. On its own initiative it inserts idle cycles (NOPs) until then. When per-command burst selection is enabled, it drives the burst-length address bit with the command.

For every command it issues, the block also predicts the cycles in which the data bus carries that burst and the cycles in which the strobe toggles, preamble and postamble included. It keeps separate predictions for the read and write directions. A request marked as forced goes out at once, whatever the spacing. When a command breaks a rule, the block raises a violation flag in the same cycle as that command.

Read latency RL is CL + AL and write latency WL is CWL + AL. The minimum column gap is TCCD. A WRITE that follows a READ waits for the turnaround gap, and that gap depends on whether the READ was chopped.

Top module: `burst_chop_sched`

## Requirements
- R1: While rst_n is low: cmd_vld, cmd_a12, viol and all four window outputs are 0, and req_ready is 1.
- R2: A READ is placed on the bus no fewer than TCCD cycles after the previous command of either direction, counted between cmd_vld cycles. A READ that is already held and waiting is placed exactly at that gap.
- R3: After a chopped READ, a WRITE waits max(TCCD, RL + TCCD/2 + 2 - WL) cycles; after an 8-beat READ it waits max(TCCD, RL + TCCD + 2 - WL). After a WRITE, the next WRITE waits TCCD. A held command goes out exactly when its gap is met.
- R4: A request is taken when req_valid and req_ready are both 1 at a clock edge, and req_ready stays 0 while a request is held. When spacing already allows it, the command appears on cmd_vld/cmd_wr/cmd_bank/cmd_col two cycles after the cycle in which the request was presented.
- R5: mode_bl selects the burst length: 2'b01 lets each request choose, with cmd_a12 = req_bl8 and a chop when req_bl8 = 0; 2'b10 chops every command; 2'b00 and 2'b11 give 8 beats to every command. cmd_a12 is 0 outside mode 2'b01 and whenever cmd_vld is 0.
- R6: For a READ with cmd_vld high in cycle t, rd_dq_win is high from t+RL for 4 cycles (8 beats) or 2 cycles (chop). rd_dqs_win is high from t+RL-1 through the cycle after the last data cycle.
- R7: For a WRITE with cmd_vld high in cycle t, wr_dq_win is high from t+WL for 4 cycles (8 beats) or 2 cycles (chop). wr_dqs_win is high from t+WL-1 through the cycle after the last data cycle.
- R8: A request with req_force = 1 is issued in the cycle after it is taken, whatever the spacing. viol is high together with that cmd_vld exactly when the spacing of R2/R3 was not met.
- R9: If req_bl8 = 1 while mode_bl is not 2'b01, the command is still issued, with cmd_a12 = 0 and the mode's burst length, and viol is high with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bl | input | 2 | Burst-length mode (01 per command, 10 chop, 00/11 eight beats) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_wr | input | 1 | 1 = WRITE, 0 = READ |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request column |
| req_bl8 | input | 1 | Request asks for 8 beats |
| req_force | input | 1 | Issue without waiting for spacing |
| cmd_vld | output | 1 | Command on the bus this cycle |
| cmd_wr | output | 1 | Command is a WRITE |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| cmd_a12 | output | 1 | Burst-length address bit (1 = 8 beats) |
| viol | output | 1 | Rule broken by the command in this cycle |
| rd_dqs_win | output | 1 | Read strobe window |
| rd_dq_win | output | 1 | Read data window |
| wr_dqs_win | output | 1 | Write strobe window |
| wr_dq_win | output | 1 | Write data window |

## Verification
A taken request is due on the command outputs two cycles after the cycle in which it was presented, or later by the outstanding gap. The windows follow the command by RL or WL cycles, less one for the preamble. The bench advances a behavioural model once per clock. The model tracks absolute cycle numbers, the time of the last command and a ring of expected window bits keyed by cycle. The outputs are sampled on the falling edge and compared against what the model has scheduled for exactly that cycle. The bench uses a read latency larger than the write latency, so that the chopped and full turnaround gaps both differ from TCCD and from each other.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    BL_FIXED8 = 2'b00,
    BL_OTF    = 2'b01,
    BL_FIXED4 = 2'b10,
    BL_RSVD   = 2'b11
  } bl_mode_e;

  localparam int BURST_CLK_LONG = 4;
  localparam int BURST_CLK_CHOP = 2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimum READ-to-WRITE gap in clocks, never below the column gap
  function automatic int rd2wr_gap(input int rl, input int wl, input int tccd, input bit chop);
    int base;
    base = rl + (chop ? tccd / 2 : tccd) + 2 - wl;
    return imax(base, tccd);
  endfunction

endpackage

// File: rtl/bcs_spacing.sv
module bcs_spacing #(
  parameter int RL   = 5,
  parameter int WL   = 5,
  parameter int TCCD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic issue_wr,
  input  logic issue_chop,
  output logic rd_ok,
  output logic wr_ok
);
  import bcs_pkg::*;

  localparam int GAP_RW_CHOP = rd2wr_gap(RL, WL, TCCD, 1'b1);
  localparam int GAP_RW_LONG = rd2wr_gap(RL, WL, TCCD, 1'b0);
  localparam int GAP_MAX     = imax(imax(GAP_RW_CHOP, GAP_RW_LONG), TCCD);
  localparam int CW          = $clog2(GAP_MAX + 1);

  localparam logic [CW-1:0] LD_CCD  = CW'(TCCD - 1);
  localparam logic [CW-1:0] LD_CHOP = CW'(GAP_RW_CHOP - 1);
  localparam logic [CW-1:0] LD_LONG = CW'(GAP_RW_LONG - 1);

  logic [CW-1:0] rd_wait_q, rd_wait_d;
  logic [CW-1:0] wr_wait_q, wr_wait_d;

  always_comb begin
    rd_wait_d = (rd_wait_q == '0) ? '0 : rd_wait_q - 1'b1;
    wr_wait_d = (wr_wait_q == '0) ? '0 : wr_wait_q - 1'b1;
    if (issue) begin
      rd_wait_d = LD_CCD;
      if (issue_wr) begin
        wr_wait_d = LD_CCD;
      end else begin
        wr_wait_d = issue_chop ? LD_CHOP : LD_LONG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait_q <= '0;
      wr_wait_q <= '0;
    end else begin
      rd_wait_q <= rd_wait_d;
      wr_wait_q <= wr_wait_d;
    end
  end

  assign rd_ok = (rd_wait_q == '0);
  assign wr_ok = (wr_wait_q == '0);

endmodule

// File: rtl/bcs_window.sv
module bcs_window #(
  parameter int LAT   = 5,
  parameter int DEPTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic chop,
  output logic dq_win,
  output logic dqs_win
);
  import bcs_pkg::*;

  // bit k of a line is the window state k cycles after the command cycle
  logic [DEPTH-1:0] dq_q, dq_d, dqs_q, dqs_d;
  logic [DEPTH-1:0] dq_mask, dqs_mask;

  always_comb begin
    int len;
    len = chop ? BURST_CLK_CHOP : BURST_CLK_LONG;
    for (int k = 0; k < DEPTH; k++) begin
      dq_mask[k]  = (k >= LAT) && (k < LAT + len);
      dqs_mask[k] = (k >= LAT - 1) && (k <= LAT + len);
    end
  end

  always_comb begin
    dq_d  = {1'b0, dq_q[DEPTH-1:1]};
    dqs_d = {1'b0, dqs_q[DEPTH-1:1]};
    if (load) begin
      dq_d  = dq_d | dq_mask;
      dqs_d = dqs_d | dqs_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q  <= '0;
      dqs_q <= '0;
    end else begin
      dq_q  <= dq_d;
      dqs_q <= dqs_d;
    end
  end

  assign dq_win  = dq_q[0];
  assign dqs_win = dqs_q[0];

endmodule

// File: rtl/burst_chop_sched.sv
module burst_chop_sched #(
  parameter int CL     = 5,
  parameter int CWL    = 5,
  parameter int AL     = 0,
  parameter int TCCD   = 4,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_bl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_bl8,
  input  logic              req_force,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_a12,
  output logic              viol,
  output logic              rd_dqs_win,
  output logic              rd_dq_win,
  output logic              wr_dqs_win,
  output logic              wr_dq_win
);
  import bcs_pkg::*;

  localparam int RL    = CL + AL;
  localparam int WL    = CWL + AL;
  localparam int DEPTH = imax(RL, WL) + BURST_CLK_LONG + 1;

  // held request
  logic              hold_vld_q, hold_vld_d;
  logic              hold_wr_q, hold_bl8_q, hold_force_q;
  logic [BANK_W-1:0] hold_bank_q;
  logic [COL_W-1:0]  hold_col_q;

  // decision signals
  logic accept, issue, dir_ok, rd_ok, wr_ok;
  logic otf, chop_sel, a12_sel, bad_a12, viol_d;

  // command register
  logic              cmd_vld_q, cmd_wr_q, cmd_a12_q, viol_q;
  logic [BANK_W-1:0] cmd_bank_q;
  logic [COL_W-1:0]  cmd_col_q;

  logic [1:0] dq_w, dqs_w;

  assign req_ready = ~hold_vld_q;
  assign accept    = req_valid & req_ready;

  always_comb begin
    otf      = (bl_mode_e'(mode_bl) == BL_OTF);
    chop_sel = otf ? ~hold_bl8_q : (bl_mode_e'(mode_bl) == BL_FIXED4);
    a12_sel  = otf & hold_bl8_q;
    bad_a12  = hold_bl8_q & ~otf;
    dir_ok   = hold_wr_q ? wr_ok : rd_ok;
    issue    = hold_vld_q & (dir_ok | hold_force_q);
    viol_d   = issue & (~dir_ok | bad_a12);
  end

  always_comb begin
    hold_vld_d = hold_vld_q;
    if (issue) hold_vld_d = 1'b0;
    if (accept) hold_vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q   <= 1'b0;
      hold_wr_q    <= 1'b0;
      hold_bl8_q   <= 1'b0;
      hold_force_q <= 1'b0;
      hold_bank_q  <= '0;
      hold_col_q   <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      if (accept) begin
        hold_wr_q    <= req_wr;
        hold_bl8_q   <= req_bl8;
        hold_force_q <= req_force;
        hold_bank_q  <= req_bank;
        hold_col_q   <= req_col;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld_q  <= 1'b0;
      cmd_a12_q  <= 1'b0;
      viol_q     <= 1'b0;
      cmd_wr_q   <= 1'b0;
      cmd_bank_q <= '0;
      cmd_col_q  <= '0;
    end else begin
      cmd_vld_q <= issue;
      cmd_a12_q <= issue & a12_sel;
      viol_q    <= viol_d;
      if (issue) begin
        cmd_wr_q   <= hold_wr_q;
        cmd_bank_q <= hold_bank_q;
        cmd_col_q  <= hold_col_q;
      end
    end
  end

  bcs_spacing #(.RL(RL), .WL(WL), .TCCD(TCCD)) u_spacing (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_wr   (hold_wr_q),
    .issue_chop (chop_sel),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok)
  );

  // index 0 = read direction, index 1 = write direction
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int LAT = (d == 1) ? WL : RL;
    bcs_window #(.LAT(LAT), .DEPTH(DEPTH)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (issue && (hold_wr_q == 1'(d))),
      .chop    (chop_sel),
      .dq_win  (dq_w[d]),
      .dqs_win (dqs_w[d])
    );
  end

  assign cmd_vld    = cmd_vld_q;
  assign cmd_wr     = cmd_wr_q;
  assign cmd_bank   = cmd_bank_q;
  assign cmd_col    = cmd_col_q;
  assign cmd_a12    = cmd_a12_q;
  assign viol       = viol_q;
  assign rd_dq_win  = dq_w[0];
  assign rd_dqs_win = dqs_w[0];
  assign wr_dq_win  = dq_w[1];
  assign wr_dqs_win = dqs_w[1];

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int CL   = 5,
  parameter int CWL  = 5,
  parameter int AL   = 0,
  parameter int TCCD = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_vld,
  input logic cmd_wr,
  input logic cmd_a12,
  input logic viol,
  input logic req_ready,
  input logic rd_dqs_win,
  input logic rd_dq_win,
  input logic wr_dqs_win,
  input logic wr_dq_win
);
  import bcs_pkg::*;

  localparam int RL = CL + AL;
  localparam int WL = CWL + AL;
  localparam logic [7:0] MIN_CCD = 8'(TCCD);
  localparam logic [7:0] MIN_RW  = 8'(rd2wr_gap(RL, WL, TCCD, 1'b1));

  logic [7:0] since_q;
  logic       seen_q, last_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q   <= '0;
      seen_q    <= 1'b0;
      last_wr_q <= 1'b0;
    end else if (cmd_vld) begin
      since_q   <= 8'd1;
      seen_q    <= 1'b1;
      last_wr_q <= cmd_wr;
    end else if (since_q != 8'hFF) begin
      since_q <= since_q + 8'd1;
    end
  end

  a_r2_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && seen_q && !viol) |-> (since_q >= MIN_CCD));

  a_r3_rd_to_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_wr && seen_q && !last_wr_q && !viol) |-> (since_q >= MIN_RW));

  a_r4_ready_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> req_ready);

  a_r5_a12_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a12 |-> cmd_vld);

  a_r8_viol_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> cmd_vld);

  a_r6_rd_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_dq_win) |-> $past(rd_dqs_win));

  a_r6_rd_postamble: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_dq_win) |-> rd_dqs_win);

  a_r7_wr_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_dq_win) |-> $past(wr_dqs_win));

  a_r7_wr_postamble: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_dq_win) |-> wr_dqs_win);

endmodule

bind burst_chop_sched bcs_checker #(.CL(CL), .CWL(CWL), .AL(AL), .TCCD(TCCD)) u_bcs_chk (.*);

// File: tb/tb_burst_chop_sched.sv
`timescale 1ns/1ps
module tb_burst_chop_sched;

  localparam int CL = 6, CWL = 5, AL = 0, TCCD = 4, BANK_W = 3, COL_W = 10;
  localparam int RL = CL + AL, WL = CWL + AL;
  localparam int GAP_RWC = 5;  // max(4, 6+2+2-5)
  localparam int GAP_RWL = 7;  // max(4, 6+4+2-5)

  logic clk, rst_n;
  logic [1:0] mode_bl;
  logic req_valid, req_ready, req_wr, req_bl8, req_force;
  logic [BANK_W-1:0] req_bank;
  logic [COL_W-1:0] req_col;
  logic cmd_vld, cmd_wr, cmd_a12, viol;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0] cmd_col;
  logic rd_dqs_win, rd_dq_win, wr_dqs_win, wr_dq_win;

  burst_chop_sched #(.CL(CL), .CWL(CWL), .AL(AL), .TCCD(TCCD), .BANK_W(BANK_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_bl(mode_bl), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_bank(req_bank), .req_col(req_col), .req_bl8(req_bl8), .req_force(req_force),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_a12(cmd_a12),
    .viol(viol), .rd_dqs_win(rd_dqs_win), .rd_dq_win(rd_dq_win), .wr_dqs_win(wr_dqs_win),
    .wr_dq_win(wr_dq_win));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  bit m_hold, m_wr, m_bl8, m_force;
  logic [BANK_W-1:0] m_bank;
  logic [COL_W-1:0] m_col;
  bit have_last, last_wr, last_chop;
  int last_t;
  bit p_vld, p_wr, p_a12, p_viol, p_bad;
  logic [BANK_W-1:0] p_bank;
  logic [COL_W-1:0] p_col;
  bit e_rdq[64], e_rdqs[64], e_wdq[64], e_wdqs[64];
  int seed = 32'h1234_5678;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    bit hold_cur, ok, otf, chop;
    int need, lat, len, t;
    hold_cur = m_hold;
    p_vld = 0; p_a12 = 0; p_viol = 0; p_bad = 0;
    if (hold_cur) begin
      if (!have_last) need = 0;
      else if (m_wr && !last_wr) need = last_chop ? GAP_RWC : GAP_RWL;
      else need = TCCD;
      ok = !have_last || ((cyc + 1 - last_t) >= need);
      if (ok || m_force) begin
        otf = (mode_bl == 2'b01);
        chop = otf ? !m_bl8 : (mode_bl == 2'b10);
        t = cyc + 1;
        p_vld = 1; p_wr = m_wr; p_bank = m_bank; p_col = m_col;
        p_a12 = otf && m_bl8;
        p_bad = m_bl8 && !otf;
        p_viol = !ok || p_bad;
        lat = m_wr ? WL : RL;
        len = chop ? 2 : 4;
        for (int k = lat - 1; k <= lat + len; k++) begin
          if (m_wr) e_wdqs[(t + k) % 64] = 1; else e_rdqs[(t + k) % 64] = 1;
        end
        for (int k = lat; k < lat + len; k++) begin
          if (m_wr) e_wdq[(t + k) % 64] = 1; else e_rdq[(t + k) % 64] = 1;
        end
        have_last = 1; last_t = t; last_wr = m_wr; last_chop = chop;
        m_hold = 0;
      end
    end
    if (req_valid && !hold_cur) begin
      m_hold = 1; m_wr = req_wr; m_bl8 = req_bl8; m_force = req_force;
      m_bank = req_bank; m_col = req_col;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk("R4", "req_ready", 32'(req_ready), 32'(!m_hold));
    chk((p_wr && p_vld) ? "R3" : "R2", "cmd_vld", 32'(cmd_vld), 32'(p_vld));
    chk("R5", "cmd_a12", 32'(cmd_a12), 32'(p_a12));
    chk(p_bad ? "R9" : "R8", "viol", 32'(viol), 32'(p_viol));
    if (p_vld && cmd_vld) begin
      chk("R4", "cmd_wr", 32'(cmd_wr), 32'(p_wr));
      chk("R4", "cmd_bank", 32'(cmd_bank), 32'(p_bank));
      chk("R4", "cmd_col", 32'(cmd_col), 32'(p_col));
    end
    chk("R6", "rd_dq_win", 32'(rd_dq_win), 32'(e_rdq[cyc % 64]));
    chk("R6", "rd_dqs_win", 32'(rd_dqs_win), 32'(e_rdqs[cyc % 64]));
    chk("R7", "wr_dq_win", 32'(wr_dq_win), 32'(e_wdq[cyc % 64]));
    chk("R7", "wr_dqs_win", 32'(wr_dqs_win), 32'(e_wdqs[cyc % 64]));
    e_rdq[cyc % 64] = 0; e_rdqs[cyc % 64] = 0; e_wdq[cyc % 64] = 0; e_wdqs[cyc % 64] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(bit wr, int bank, int col, bit bl8, bit frc);
    while (m_hold) tick();
    req_valid = 1; req_wr = wr; req_bank = BANK_W'(bank); req_col = COL_W'(col);
    req_bl8 = bl8; req_force = frc;
    tick();
    req_valid = 0; req_force = 0;
  endtask

  task automatic set_mode(logic [1:0] m);
    while (m_hold) tick();
    mode_bl = m;
  endtask

  initial begin
    rst_n = 0; mode_bl = 2'b01; req_valid = 0; req_wr = 0; req_bank = '0; req_col = '0;
    req_bl8 = 0; req_force = 0;
    m_hold = 0; have_last = 0; last_t = 0; last_wr = 0; last_chop = 0;
    for (int i = 0; i < 64; i++) begin
      e_rdq[i] = 0; e_rdqs[i] = 0; e_wdq[i] = 0; e_wdqs[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cmd_vld", 32'(cmd_vld), 0);
    chk("R1", "cmd_a12", 32'(cmd_a12), 0);
    chk("R1", "viol", 32'(viol), 0);
    chk("R1", "windows", 32'({rd_dqs_win, rd_dq_win, wr_dqs_win, wr_dq_win}), 0);
    chk("R1", "req_ready", 32'(req_ready), 1);
    rst_n = 1;
    idle(2);

    // per-command burst choice: R2 read-read, R3 turnarounds, R6/R7 windows
    set_mode(2'b01);
    send(0, 1, 10'h010, 1, 0);
    send(0, 2, 10'h020, 0, 0);
    send(1, 3, 10'h030, 1, 0);
    send(1, 4, 10'h040, 0, 0);
    send(0, 5, 10'h050, 1, 0);
    send(1, 6, 10'h060, 1, 0);
    idle(16);
    // fixed chop mode, R5
    set_mode(2'b10);
    send(0, 7, 10'h111, 0, 0);
    send(1, 0, 10'h222, 0, 0);
    idle(16);
    // fixed eight-beat mode with illegal burst request, R9
    set_mode(2'b00);
    send(0, 1, 10'h0AA, 0, 0);
    send(0, 2, 10'h0BB, 1, 0);
    idle(16);
    set_mode(2'b11);
    send(1, 3, 10'h0CC, 0, 0);
    send(1, 4, 10'h0DD, 1, 0);
    idle(16);
    // forced issue, R8: early then on time
    set_mode(2'b01);
    send(0, 5, 10'h100, 1, 0);
    send(0, 6, 10'h101, 1, 1);
    send(1, 7, 10'h102, 0, 1);
    idle(12);
    send(0, 0, 10'h103, 0, 1);
    idle(16);

    // pseudo-random traffic
    for (int b = 0; b < 40; b++) begin
      seed = seed * 1103515245 + 12345;
      set_mode(2'(seed >>> 16));
      for (int r = 0; r < 8; r++) begin
        seed = seed * 1103515245 + 12345;
        send(seed[20], int'(seed[23:21]), int'(seed[17:8]), seed[24],
             (seed[30:27] == 4'd0));
        idle(int'(seed[26:25]));
      end
    end
    idle(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule